// File: doc/BRIEF.md
# SD Card Data FIFO and Byte Engine

This block sits between a 32-bit data register and a byte-wide card data path. Software appends words to a 16-entry circular word buffer by writing the data port and takes the oldest word by reading it. When the read direction is selected, the engine gathers bytes arriving from the card into words and appends them to the buffer. When the write direction is selected, it takes words from the buffer and sends their bytes to the card.

A remaining-byte counter, loaded with block size times block count, limits every transfer. The engine stops when the counter reaches zero, and the state field then reports data mode. Each word the engine moves raises a sticky data flag, and an interrupt flag as well when data interrupts are enabled. In the write direction, the end of each block raises a block flag. The command decoder and the response path sit outside this block and select the direction through two level inputs.

Top module: `sd_data_engine`

## Requirements
- R1: The buffer holds 16 words of 32 bits. A data write appends a word. A data read takes the oldest word, which `dat_rd_data` shows in the same cycle as the read. `dbg_o[8:4]` shows the current word count.
- R2: An append while 16 words are held is dropped. The count stays 16 and the stored words do not change.
- R3: While the buffer is empty, `dat_rd_data` is 0, and a read leaves the count at 0.
- R4: A block-count write loads the remaining-byte counter with `blkcnt_wr_data * blk_size`. Exactly that many card bytes then move before the engine stops.
- R5: `card_rx_ready` is high only when `dir_read` is 1, the counter is nonzero, fewer than 16 words are held, and no data write happens in that cycle. A byte moves when `card_rx_valid` and `card_rx_ready` are both high.
- R6: Received bytes are packed little-endian: the first byte goes to bits 7:0. A word is appended after four bytes, or after the byte that brings the counter to 0; unfilled upper bytes are zero.
- R7: The write direction is active when `dir_write` is 1 and `dir_read` is 0. The engine takes a word and sends its bytes least significant first, one per handshake. The counter drops by one per byte. Bytes still unsent when the counter reaches 0 are dropped.
- R8: Each word the engine appends or takes sets `status_o[0]`. It also sets `status_o[8]` when `cfg_data_irq_en` is 1.
- R9: In the write direction, `status_o[9]` is set after every `blk_size` sent bytes when `cfg_blk_irq_en` is 1 and `blk_size` is nonzero.
- R10: `dbg_o[3:0]` becomes 1 when a byte transfer brings the counter to 0. A state write stores `state_wr_data`, except that 15 is stored as 0. When both happen in the same cycle, the transfer wins.
- R11: A status clear resets the bits set in `sts_clr_mask`. A flag set in the same cycle wins over the clear. `irq_o` is `status_o[8] | status_o[9]`.
- R12: After reset the buffer is empty, the counter is 0, the status is 0 and the state field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dat_wr_en | input | 1 | Data register write strobe |
| dat_wr_data | input | 32 | Word to append |
| dat_rd_en | input | 1 | Data register read strobe |
| dat_rd_data | output | 32 | Oldest word, or 0 when empty |
| dir_read | input | 1 | Card-to-buffer direction select |
| dir_write | input | 1 | Buffer-to-card direction select |
| cfg_data_irq_en | input | 1 | Enables data interrupt flag |
| cfg_blk_irq_en | input | 1 | Enables block interrupt flag |
| blk_size | input | 10 | Block size in bytes |
| blkcnt_wr_en | input | 1 | Block count write strobe |
| blkcnt_wr_data | input | 9 | Block count |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_mask | input | 10 | Status bits to clear |
| state_wr_en | input | 1 | State field write strobe |
| state_wr_data | input | 4 | State value |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Engine takes card byte |
| card_tx_valid | output | 1 | Byte for card available |
| card_tx_data | output | 8 | Byte for card |
| card_tx_ready | input | 1 | Card takes byte |
| status_o | output | 10 | Sticky flags: bit 0 data, bit 8 data irq, bit 9 block irq |
| irq_o | output | 1 | Interrupt request |
| dbg_o | output | 9 | Bits 8:4 word count, bits 3:0 state |

## Verification
A corrupted buffer pointer or word count shows at the ports in the same cycle. `dat_rd_data` returns a stale or wrong word, or `dbg_o[8:4]` disagrees, and the gating of `card_rx_ready` goes wrong. A packing phase that has slipped shows as misplaced bytes in the next appended word. A wrong remaining-byte or block counter shows as an extra or missing handshake, or as a block flag in the wrong cycle, at the end of the transfer. The bench checks every output against its model on every clock, so any of these is reported within one cycle of reaching a port.

// File: rtl/sdfe_pkg.sv
// Shared sizing and status-bit layout for the SD data engine.
// Assumes a power-of-two buffer depth and 8-bit card lanes.
package sdfe_pkg;
    parameter int WORD_W     = 32;
    parameter int FIFO_DEPTH = 16;
    parameter int BS_W       = 10;
    parameter int BC_W       = 9;
    parameter int ST_W       = 10;
    parameter int ST_DATA    = 0;
    parameter int ST_DIRQ    = 8;
    parameter int ST_BIRQ    = 9;
    parameter int STATE_W    = 4;
    localparam logic [3:0] STATE_DATAMODE = 4'd1;
    localparam logic [3:0] STATE_PWRDOWN  = 4'hF;
endpackage

// File: rtl/sdfe_fifo.sv
// Circular word buffer. A pop takes effect before a push in the same cycle,
// so a push while full succeeds only if a pop frees an entry. Head reads 0 when empty.
module sdfe_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          do_pop, do_push;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = empty ? '0 : mem[rd_ptr];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == LW'(DEPTH)));
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/sdfe_pack.sv
// Gathers card bytes little-endian into a word. Emits the word after the last
// lane, or early (zero-padded) when 'last' marks the final byte of the transfer.
module sdfe_pack #(
    parameter int W  = 32,
    localparam int NB = W / 8,
    localparam int PW = $clog2(NB)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         take,
    input  logic [7:0]   byte_in,
    input  logic         last,
    output logic         word_push,
    output logic [W-1:0] word_out
);
    logic [W-1:0]  acc;
    logic [PW-1:0] ph;

    assign word_out  = acc | (W'(byte_in) << (8 * ph));
    assign word_push = take && ((ph == PW'(NB - 1)) || last);

    // Lane phase and partial-word accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
            ph  <= '0;
        end else if (word_push) begin
            acc <= '0;
            ph  <= '0;
        end else if (take) begin
            acc <= word_out;
            ph  <= ph + 1'b1;
        end
    end

    p_phase_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_push |=> (ph == '0));
endmodule

// File: rtl/sdfe_unpack.sv
// Holds one word and shifts it out byte by byte, least significant first.
// Assumes 'load' is only raised when no bytes remain.
module sdfe_unpack #(
    parameter int W  = 32,
    localparam int NB = W / 8,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         take,
    output logic         valid,
    output logic [7:0]   byte_out
);
    logic [W-1:0]  word;
    logic [CW-1:0] left;

    assign valid    = (left != '0);
    assign byte_out = word[7:0];

    // Word register and remaining-lane count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            left <= '0;
            word <= '0;
        end else if (load) begin
            word <= load_word;
            left <= CW'(NB);
        end else if (take) begin
            word <= word >> 8;
            left <= left - 1'b1;
        end
    end

    p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);
endmodule

// File: rtl/sd_data_engine.sv
// Top of the SD data engine: remaining-byte counter, block counter, status
// flags, state field, and direction gating around buffer, packer and unpacker.
// Assumes the register file holds block size and direction selects as levels.
module sd_data_engine
    import sdfe_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int SZ_W   = BS_W,
    parameter int CNT_IN = BC_W,
    localparam int LW    = $clog2(DEPTH + 1),
    localparam int CW    = SZ_W + CNT_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_wr_en,
    input  logic [W-1:0]      dat_wr_data,
    input  logic              dat_rd_en,
    output logic [W-1:0]      dat_rd_data,
    input  logic              dir_read,
    input  logic              dir_write,
    input  logic              cfg_data_irq_en,
    input  logic              cfg_blk_irq_en,
    input  logic [SZ_W-1:0]   blk_size,
    input  logic              blkcnt_wr_en,
    input  logic [CNT_IN-1:0] blkcnt_wr_data,
    input  logic              sts_clr_en,
    input  logic [ST_W-1:0]   sts_clr_mask,
    input  logic              state_wr_en,
    input  logic [STATE_W-1:0] state_wr_data,
    input  logic              card_rx_valid,
    input  logic [7:0]        card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_data,
    input  logic              card_tx_ready,
    output logic [ST_W-1:0]   status_o,
    output logic              irq_o,
    output logic [LW+STATE_W-1:0] dbg_o
);
    logic [CW-1:0]      cnt;
    logic [SZ_W-1:0]    blk_left;
    logic [STATE_W-1:0] state;
    logic               f_full, f_empty;
    logic [LW-1:0]      f_level;
    logic [W-1:0]       f_head, pk_word;
    logic               pk_push, up_valid;
    logic               rd_mode, wr_mode, cnt_nz, last;
    logic               rx_take, tx_take, eng_pop, word_evt, zero_evt;
    logic [ST_W-1:0]    set_v;

    assign rd_mode       = dir_read;
    assign wr_mode       = dir_write && !dir_read;
    assign cnt_nz        = (cnt != '0);
    assign last          = (cnt == CW'(1));
    assign card_rx_ready = rd_mode && cnt_nz && !f_full && !dat_wr_en;
    assign rx_take       = card_rx_ready && card_rx_valid;
    assign card_tx_valid = wr_mode && cnt_nz && up_valid;
    assign tx_take       = card_tx_valid && card_tx_ready;
    assign eng_pop       = wr_mode && cnt_nz && !up_valid && !f_empty && !dat_rd_en;
    assign word_evt      = pk_push || eng_pop;
    assign zero_evt      = (rx_take || tx_take) && last && !blkcnt_wr_en;
    assign dat_rd_data   = f_head;
    assign irq_o         = status_o[ST_DIRQ] | status_o[ST_BIRQ];
    assign dbg_o         = {f_level, state};

    sdfe_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(dat_wr_en || pk_push),
        .push_data(dat_wr_en ? dat_wr_data : pk_word),
        .pop(dat_rd_en || eng_pop),
        .head(f_head), .full(f_full), .empty(f_empty), .level(f_level)
    );

    sdfe_pack #(.W(W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(blkcnt_wr_en),
        .take(rx_take), .byte_in(card_rx_data), .last(last),
        .word_push(pk_push), .word_out(pk_word)
    );

    sdfe_unpack #(.W(W)) u_unpack (
        .clk(clk), .rst_n(rst_n),
        .clear(blkcnt_wr_en || (tx_take && last)),
        .load(eng_pop), .load_word(f_head), .take(tx_take),
        .valid(up_valid), .byte_out(card_tx_data)
    );

    // Remaining-byte counter: load wins over per-byte decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (blkcnt_wr_en)
            cnt <= CW'(blkcnt_wr_data) * CW'(blk_size);
        else if (rx_take || tx_take)
            cnt <= cnt - 1'b1;
    end

    // Bytes left in the current outgoing block; reloads at each block end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_left <= '0;
        else if (blkcnt_wr_en)
            blk_left <= blk_size;
        else if (tx_take)
            blk_left <= (blk_left == SZ_W'(1)) ? blk_size : blk_left - 1'b1;
    end

    // Flag set vector for this cycle.
    always_comb begin
        set_v          = '0;
        set_v[ST_DATA] = word_evt;
        set_v[ST_DIRQ] = word_evt && cfg_data_irq_en;
        set_v[ST_BIRQ] = tx_take && (blk_left == SZ_W'(1)) && cfg_blk_irq_en
                         && (blk_size != '0);
    end

    // Sticky status: clear first, then set, so a new event is never lost.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_o <= '0;
        else
            status_o <= (sts_clr_en ? (status_o & ~sts_clr_mask) : status_o) | set_v;
    end

    // State field: transfer end wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= '0;
        else if (zero_evt)
            state <= STATE_DATAMODE;
        else if (state_wr_en)
            state <= (state_wr_data == STATE_PWRDOWN) ? '0 : state_wr_data;
    end

    p_rx_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_nz |-> !card_rx_ready);
    p_rx_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> (f_level < LW'(DEPTH)));
    p_tx_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !blkcnt_wr_en) |=> (cnt == $past(cnt) - 1'b1));
    p_data_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_evt |=> status_o[ST_DATA]);
    p_blk_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ST_BIRQ]) |-> $past(tx_take));
    p_state_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_nz) && !cnt_nz && !$past(blkcnt_wr_en)) |-> (state == STATE_DATAMODE));
endmodule

// File: tb/sd_data_engine_tb.sv
`timescale 1ns/1ps
module sd_data_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dat_wr_en, dat_rd_en, dir_read, dir_write;
    logic [31:0] dat_wr_data, dat_rd_data;
    logic        cfg_die, cfg_bie, blkcnt_wr_en, sts_clr_en, state_wr_en;
    logic [9:0]  blk_size, sts_clr_mask, status_o;
    logic [8:0]  blkcnt_wr_data, dbg_o;
    logic [3:0]  state_wr_data;
    logic        rx_valid, rx_ready, tx_valid, tx_ready, irq_o;
    logic [7:0]  rb, tx_data;

    int tests = 0, fails = 0, cyc = 0, rx_count = 0;
    int unsigned mq[$];
    logic [7:0]  txq[$];
    int          mcnt, mph, mtxl, mblk;
    logic [31:0] macc, mtxw;
    logic [9:0]  mst;
    logic [3:0]  mstate;

    always #2.5 clk = ~clk;

    sd_data_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .dat_wr_en(dat_wr_en), .dat_wr_data(dat_wr_data),
        .dat_rd_en(dat_rd_en), .dat_rd_data(dat_rd_data),
        .dir_read(dir_read), .dir_write(dir_write),
        .cfg_data_irq_en(cfg_die), .cfg_blk_irq_en(cfg_bie),
        .blk_size(blk_size), .blkcnt_wr_en(blkcnt_wr_en), .blkcnt_wr_data(blkcnt_wr_data),
        .sts_clr_en(sts_clr_en), .sts_clr_mask(sts_clr_mask),
        .state_wr_en(state_wr_en), .state_wr_data(state_wr_data),
        .card_rx_valid(rx_valid), .card_rx_data(rb), .card_rx_ready(rx_ready),
        .card_tx_valid(tx_valid), .card_tx_data(tx_data), .card_tx_ready(tx_ready),
        .status_o(status_o), .irq_o(irq_o), .dbg_o(dbg_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            summary();
        end
    end

    task automatic idle_in();
        dat_wr_en = 0; dat_rd_en = 0; blkcnt_wr_en = 0; sts_clr_en = 0;
        state_wr_en = 0; dat_wr_data = '0; sts_clr_mask = '0; state_wr_data = '0;
    endtask

    // Compare every output with the reference, then advance one clock.
    task automatic step();
        bit rxr, txv, rxt, txt, ep, last, zero;
        logic [31:0] w;
        logic [9:0]  setv;
        #1;
        rxr = dir_read && mcnt != 0 && mq.size() < 16 && !dat_wr_en;
        txv = dir_write && !dir_read && mcnt != 0 && mtxl != 0;
        check("R1", "rd_data", dat_rd_data, mq.size() > 0 ? mq[0] : 32'h0);
        check("R1", "level", dbg_o[8:4], mq.size());
        check("R5", "rx_ready", rx_ready, rxr);
        check("R7", "tx_valid", tx_valid, txv);
        if (txv) check("R7", "tx_data", tx_data, mtxw[7:0]);
        check("R8", "status", status_o, mst);
        check("R10", "state", dbg_o[3:0], mstate);
        check("R11", "irq", irq_o, mst[8] | mst[9]);
        rxt = rxr && rx_valid;
        txt = txv && tx_ready;
        if (txt) txq.push_back(tx_data);
        ep = dir_write && !dir_read && mcnt != 0 && mtxl == 0 && mq.size() > 0 && !dat_rd_en;
        last = (mcnt == 1);
        zero = 0;
        setv = '0;
        @(posedge clk);
        if (dat_rd_en && mq.size() > 0) void'(mq.pop_front());
        if (ep) begin mtxw = mq.pop_front(); mtxl = 4; setv[0] = 1; setv[8] = cfg_die; end
        if (rxt) begin
            rx_count++;
            w = macc | (32'(rb) << (8 * mph));
            if (mph == 3 || last) begin
                if (mq.size() < 16) mq.push_back(w);
                macc = 0; mph = 0; setv[0] = 1; setv[8] = cfg_die;
            end else begin
                macc = w; mph++;
            end
        end
        if (dat_wr_en && mq.size() < 16) mq.push_back(dat_wr_data);
        if (txt) begin
            mtxw = mtxw >> 8; mtxl--;
            if (mblk == 1) begin
                if (cfg_bie && blk_size != 0) setv[9] = 1;
                mblk = blk_size;
            end else mblk--;
            if (last) mtxl = 0;
        end
        if (rxt || txt) begin mcnt--; zero = (mcnt == 0); end
        if (blkcnt_wr_en) begin
            mcnt = blkcnt_wr_data * blk_size; mph = 0; macc = 0; mtxl = 0;
            mblk = blk_size; zero = 0;
        end
        if (sts_clr_en) mst = mst & ~sts_clr_mask;
        mst = mst | setv;
        if (zero) mstate = 1;
        else if (state_wr_en) mstate = (state_wr_data == 4'hF) ? 4'h0 : state_wr_data;
        @(negedge clk);
        if (rxt) rb = rb + 1;
        idle_in();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        rst_n = 0; idle_in(); dir_read = 0; dir_write = 0; cfg_die = 0; cfg_bie = 0;
        blk_size = 0; blkcnt_wr_data = 0; rx_valid = 0; tx_ready = 0; rb = 8'h11;
        mcnt = 0; mph = 0; mtxl = 0; mblk = 0; macc = 0; mtxw = 0; mst = 0; mstate = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R12: reset state at the ports
        check("R12", "level after reset", dbg_o[8:4], 0);
        check("R12", "status after reset", status_o, 0);
        check("R12", "state after reset", dbg_o[3:0], 0);
        check("R12", "rx_ready after reset", rx_ready, 0);

        // R1, R2: fill with 17 words, the last one is dropped
        for (int i = 0; i < 17; i++) begin dat_wr_en = 1; dat_wr_data = 32'hA000_0000 + i; step(); end
        check("R2", "level when full", dbg_o[8:4], 16);
        check("R2", "head kept", dat_rd_data, 32'hA000_0000);
        for (int i = 0; i < 16; i++) begin dat_rd_en = 1; step(); end
        // R3: read while empty
        check("R3", "empty head", dat_rd_data, 0);
        dat_rd_en = 1; step();
        check("R3", "level after empty pop", dbg_o[8:4], 0);

        // R4, R6, R8, R10: six-byte read transfer
        cfg_die = 1; blk_size = 6; blkcnt_wr_data = 1; blkcnt_wr_en = 1; step();
        dir_read = 1; rx_valid = 1; rx_count = 0;
        run(10);
        check("R4", "bytes moved", rx_count, 6);
        check("R6", "first packed word", dat_rd_data, 32'h1413_1211);
        check("R8", "data flags", status_o & 10'h101, 10'h101);
        check("R10", "data mode", dbg_o[3:0], 1);
        dat_rd_en = 1; step();
        check("R6", "zero-padded word", dat_rd_data, 32'h0000_1615);
        dat_rd_en = 1; step();

        // R11: clear everything
        sts_clr_en = 1; sts_clr_mask = 10'h3FF; step();
        check("R11", "status cleared", status_o, 0);
        check("R11", "irq low", irq_o, 0);

        // R5: read transfer that fills the buffer, then drains
        blk_size = 8; blkcnt_wr_data = 9; blkcnt_wr_en = 1; step();
        for (int i = 0; i < 150; i++) begin rx_valid = (i % 2 == 0); step(); end
        check("R5", "level at stall", dbg_o[8:4], 16);
        check("R5", "ready low when full", rx_ready, 0);
        for (int i = 0; i < 40; i++) begin rx_valid = 1; dat_rd_en = (i % 3 == 0); step(); end
        for (int i = 0; i < 20; i++) begin dat_rd_en = 1; step(); end
        check("R4", "all 72 bytes", rx_count, 6 + 72);
        rx_valid = 0; dir_read = 0;

        // R7, R9: write transfer of three blocks of four bytes
        sts_clr_en = 1; sts_clr_mask = 10'h3FF; cfg_die = 0; cfg_bie = 1; step();
        dat_wr_en = 1; dat_wr_data = 32'h4433_2211; step();
        dat_wr_en = 1; dat_wr_data = 32'h8877_6655; step();
        dat_wr_en = 1; dat_wr_data = 32'hCCBB_AA99; step();
        blk_size = 4; blkcnt_wr_data = 3; blkcnt_wr_en = 1; step();
        dir_write = 1; txq.delete();
        for (int i = 0; i < 40; i++) begin tx_ready = (i % 3 != 0); step(); end
        check("R7", "byte count", txq.size(), 12);
        for (int i = 0; i < 12 && i < txq.size(); i++)
            check("R7", "byte order", txq[i], 8'h11 * (i + 1));
        check("R9", "block flag", status_o[9], 1);
        check("R8", "data irq off", status_o[8], 0);
        check("R8", "data flag", status_o[0], 1);

        // R7: partial word at end, leftover bytes dropped
        dir_write = 0; tx_ready = 0;
        dat_wr_en = 1; dat_wr_data = 32'h0403_0201; step();
        dat_wr_en = 1; dat_wr_data = 32'h0807_0605; step();
        blk_size = 6; blkcnt_wr_data = 1; blkcnt_wr_en = 1; step();
        dir_write = 1; tx_ready = 1; txq.delete();
        run(20);
        check("R7", "partial byte count", txq.size(), 6);
        check("R7", "tx idle after end", tx_valid, 0);
        check("R7", "buffer drained", dbg_o[8:4], 0);
        dir_write = 0;

        // R10: state writes, 15 maps to 0
        state_wr_en = 1; state_wr_data = 4'hF; step();
        check("R10", "power-down write", dbg_o[3:0], 0);
        state_wr_en = 1; state_wr_data = 4'h5; step();
        check("R10", "plain write", dbg_o[3:0], 5);
        run(3);
        summary();
    end
endmodule